// File: doc/BRIEF.md
# Region-Decoded Word Memory

This block is the main store of a small 16-bit processor. One 16-bit word address selects one 16-bit word. The address space has three fixed regions. The lowest 256 words form a read-only table whose contents are computed when the design is built. The words from 0x0100 up to 0x3FFF are writable RAM. Every address from 0x4000 upward has no storage behind it.

The processor drives an address, write data and a write strobe. Read data follows the address combinationally, so a fetch or load takes no clock cycle of its own. A write takes effect at the rising clock edge, and only when the address lies in RAM. Writes aimed at the table or at the empty region are dropped. While the active-low reset is held, no write lands.

Top module: `mem_map_top`

## Requirements
- R1: A read at any address from 0x0000 to 0x00FF returns the constant word {a[7:0] ^ 8'h5A, ~a[7:0]}, where a is the address.
- R2: With we_i high and the address between 0x0100 and 0x3FFF, wdata_i is stored at the rising clock edge. A later read of that address returns it.
- R3: rdata_o depends only on the current address and the stored contents. It changes with addr_i and needs no clock edge.
- R4: A write aimed at 0x0000 to 0x00FF has no effect, and the table value is still read back afterwards.
- R5: A read at any address from 0x4000 to 0xFFFF returns 0x0000.
- R6: A write aimed at 0x4000 to 0xFFFF changes no RAM word, including the RAM words whose low address bits it shares.
- R7: While we_i is low, a clock edge leaves every RAM word unchanged.
- R8: While rst_ni is low, a write with we_i high is not stored.
- R9: The region boundaries are exact. 0x00FF is in the table, 0x0100 and 0x3FFF are in RAM, and 0x4000 is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; RAM writes occur on its rising edge |
| rst_ni | input | 1 | Active-low reset; blocks writes while low |
| addr_i | input | 16 | Word address |
| wdata_i | input | 16 | Data to store |
| we_i | input | 1 | Write strobe; read when low |
| rdata_o | output | 16 | Word read from the current address |

## Verification
The hardest case to provoke is a write to the empty region that wrongly aliases into RAM. The RAM index uses only the low 14 address bits, so a missing range check would let 0x4100 or 0xC100 overwrite the word at 0x0100. The stimulus first fills known RAM words. It then writes different data to the aliased addresses in the empty region and reads the original words back through the normal read path. A write issued while reset is held is handled the same way: a known word is written, reset is pulsed during a write to that word, and the word is read back after reset is released.

// File: rtl/mem_map_pkg.sv
package mem_map_pkg;

  typedef enum logic [1:0] {
    RGN_ROM  = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_VOID = 2'd2
  } rgn_e;

  // constant table content, derived from the low address byte
  function automatic logic [15:0] rom_word(input logic [7:0] idx);
    return {idx ^ 8'h5A, ~idx};
  endfunction

endpackage

// File: rtl/mem_map_decode.sv
module mem_map_decode
  import mem_map_pkg::*;
#(
  parameter int AW        = 16,
  parameter int ROM_WORDS = 256,
  parameter int RAM_END   = 'h3FFF,
  parameter int RW        = 8,
  parameter int IW        = 14
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          rst_ni,
  output rgn_e          region_o,
  output logic [RW-1:0] rom_idx_o,
  output logic [IW-1:0] ram_idx_o,
  output logic          ram_we_o
);

  always_comb begin
    if (addr_i < AW'(ROM_WORDS))     region_o = RGN_ROM;
    else if (addr_i <= AW'(RAM_END)) region_o = RGN_RAM;
    else                             region_o = RGN_VOID;
  end

  assign rom_idx_o = addr_i[RW-1:0];
  assign ram_idx_o = addr_i[IW-1:0] - IW'(ROM_WORDS);
  // only RAM takes writes, and never under reset
  assign ram_we_o  = we_i & rst_ni & (region_o == RGN_RAM);

endmodule

// File: rtl/mem_map_rom.sv
module mem_map_rom #(
  parameter int WORDS = 256,
  parameter int DW    = 16,
  parameter int RW    = 8
) (
  input  logic [RW-1:0] idx_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] tbl [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_tbl
    assign tbl[g] = DW'(mem_map_pkg::rom_word(8'(g)));
  end

  assign rdata_o = tbl[idx_i];

endmodule

// File: rtl/mem_map_ram.sv
module mem_map_ram #(
  parameter int DEPTH = 16128,
  parameter int DW    = 16,
  parameter int IW    = 14
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  assign rdata_o = mem[idx_i];

endmodule

// File: rtl/mem_map_top.sv
module mem_map_top
  import mem_map_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int ROM_WORDS = 256,
  parameter int RAM_END   = 'h3FFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o
);

  localparam int RW        = $clog2(ROM_WORDS);
  localparam int RAM_WORDS = RAM_END + 1 - ROM_WORDS;
  localparam int IW        = $clog2(RAM_WORDS);

  rgn_e          region;
  logic [RW-1:0] rom_idx;
  logic [IW-1:0] ram_idx;
  logic          ram_we;
  logic [DW-1:0] rom_rd, ram_rd;

  mem_map_decode #(
    .AW(AW), .ROM_WORDS(ROM_WORDS), .RAM_END(RAM_END), .RW(RW), .IW(IW)
  ) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .rst_ni   (rst_ni),
    .region_o (region),
    .rom_idx_o(rom_idx),
    .ram_idx_o(ram_idx),
    .ram_we_o (ram_we)
  );

  mem_map_rom #(.WORDS(ROM_WORDS), .DW(DW), .RW(RW)) u_rom (
    .idx_i  (rom_idx),
    .rdata_o(rom_rd)
  );

  mem_map_ram #(.DEPTH(RAM_WORDS), .DW(DW), .IW(IW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .idx_i  (ram_idx),
    .wdata_i(wdata_i),
    .rdata_o(ram_rd)
  );

  always_comb begin
    unique case (region)
      RGN_ROM: rdata_o = rom_rd;
      RGN_RAM: rdata_o = ram_rd;
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/mem_map_chk.sv
module mem_map_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [15:0] wdata_i,
  input logic        we_i,
  input logic [15:0] rdata_o
);

  logic in_ram;
  assign in_ram = (addr_i >= 16'h0100) && (addr_i <= 16'h3FFF);

  a_r1_rom_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 16'h0100) |-> (rdata_o == {addr_i[7:0] ^ 8'h5A, ~addr_i[7:0]}));

  a_r5_void_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 16'h4000) |-> (rdata_o == 16'h0000));

  a_r2_ram_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_ram) |=> ((addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))));

  a_r7_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && !$past(we_i)) |-> $stable(rdata_o));

  a_r4_rom_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && ($past(addr_i) < 16'h0100) && $stable(addr_i)) |-> $stable(rdata_o));

endmodule

bind mem_map_top mem_map_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .we_i   (we_i),
  .rdata_o(rdata_o)
);

// File: tb/sim_mem_map_top.sv
module sim_mem_map_top;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] shadow [16384];
  bit          known  [16384];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_map_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o)
  );

  function automatic logic [15:0] tbl_val(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, ~a[7:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr_i, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (rst_ni && a >= 16'h0100 && a <= 16'h3FFF) begin
      shadow[a[13:0]] = d;
      known[a[13:0]]  = 1'b1;
    end
  endtask

  // read with model check; RAM words never written are skipped
  task automatic rd(input string req, input logic [15:0] a);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    #1;
    if (a < 16'h0100) check(req, rdata_o, tbl_val(a));
    else if (a >= 16'h4000) check(req, rdata_o, 16'h0000);
    else if (known[a[13:0]]) check(req, rdata_o, shadow[a[13:0]]);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom_range(0, 3))
      0:       return 16'($urandom_range(0, 'h00FF));
      1, 2:    return 16'($urandom_range('h0100, 'h3FFF));
      default: return 16'($urandom_range('h4000, 'hFFFF));
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16384; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk_i);

    // reset state: table and empty region readable under reset
    addr_i = 16'h0042; #1;
    check("R1 reset", rdata_o, tbl_val(16'h0042));
    addr_i = 16'h8000; #1;
    check("R5 reset", rdata_o, 16'h0000);
    rst_ni = 1'b1;

    // R9 boundaries
    rd("R9 rom top", 16'h00FF);
    rd("R9 rom bottom", 16'h0000);
    wr(16'h0100, 16'hA001);
    wr(16'h3FFF, 16'hB3FF);
    rd("R9 ram bottom", 16'h0100);
    rd("R9 ram top", 16'h3FFF);
    rd("R9 void bottom", 16'h4000);
    rd("R5 void top", 16'hFFFF);

    // R4 writes to table dropped
    wr(16'h00FF, 16'h1234);
    rd("R4 rom write", 16'h00FF);
    wr(16'h0000, 16'hFFFF);
    rd("R4 rom write", 16'h0000);

    // R6 aliasing writes into the empty region
    wr(16'h4100, 16'hDEAD);
    wr(16'hC100, 16'hBEEF);
    wr(16'h7FFF, 16'h5555);
    rd("R6 alias 0100", 16'h0100);
    rd("R6 alias 3FFF", 16'h3FFF);
    rd("R6 void read", 16'h4100);

    // R3 address change without clock edge
    wr(16'h0200, 16'h0C0C);
    @(negedge clk_i);
    addr_i = 16'h0100; #1;
    check("R3 comb a", rdata_o, 16'hA001);
    addr_i = 16'h0200; #1;
    check("R3 comb b", rdata_o, 16'h0C0C);
    addr_i = 16'h0010; #1;
    check("R3 comb rom", rdata_o, tbl_val(16'h0010));

    // R7 clock edges with we_i low
    @(negedge clk_i);
    addr_i = 16'h0200; wdata_i = 16'hFFFF; we_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1 check("R7 hold", rdata_o, 16'h0C0C);

    // R8 write under reset
    wr(16'h0300, 16'h1111);
    @(negedge clk_i) rst_ni = 1'b0;
    wr(16'h0300, 16'h2222);
    @(negedge clk_i) rst_ni = 1'b1;
    rd("R8 reset write", 16'h0300);

    // R2 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = pick_addr();
      if ($urandom_range(0, 1) == 1) wr(a, 16'($urandom()));
      else rd("R2 random", a);
    end
    for (int i = 'h0100; i < 'h0400; i += 3) rd("R2 sweep", 16'(i));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule